// File: doc/BRIEF.md
# Two-Wire Register Slave with Bus-Mode Gating

This block is the two-wire serial front end of a sensor's register bank. It watches the clock and data lines and recognises the start, repeated-start and stop conditions. It answers one fixed 7-bit device address. It turns bus frames into single-cycle register-file writes, and it returns register contents in reads of one or more bytes. An 8-bit register pointer is loaded from the first byte of every write-addressed frame. The pointer then steps forward after every byte that is written or read.

The bus pins are shared with a four-wire serial mode. The two-wire engine runs only while the chip-select input is high. The register file can also hold the engine off through a disable input, so that traffic in the four-wire mode is never taken for two-wire frames. The data line is driven only as an active-low open-drain output through `sda_oe_o`. While `sda_oe_o` is 1, the pad pulls the line to 0. Clock stretching and the sensor datapath belong to other blocks.

Top module: `i2c_regslave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `DEV_ADDR` (default 0x1D; write byte 0x3A, read byte 0x3B). Any other address gets no acknowledge, and the data line stays released until the next START. This covers general call (0x00), a 10-bit prefix (0xF0) and a high-speed master code (0x08).
- R2: While `cs_i` is 0, the engine is idle. It never asserts `sda_oe_o` or `reg_we_o`, and the register pointer is left unchanged.
- R3: While `i2c_dis_i` is 1, the engine behaves exactly as it does with `cs_i` low.
- R4: In a write frame, the slave acknowledges the byte after the address and loads that byte into the register pointer.
- R5: Each further byte of a write frame is acknowledged and appears on `reg_wdata_o` with a one-cycle `reg_we_o` pulse at `reg_addr_o` equal to the pointer. The pointer increases by one in the next cycle.
- R6: After a repeated START and the read address, the slave returns the register at the pointer, most significant bit first. A 0 bit is sent by asserting `sda_oe_o`.
- R7: The pointer increases by one after every byte read. Successive registers are returned for as long as the master acknowledges.
- R8: A master NACK ends a read burst. The slave releases the data line and drives nothing more until a START or STOP.
- R9: A STOP, or a START inside any frame, abandons the current frame: a START begins a new address phase, and a partly received byte is not written. The pointer keeps its value across both.
- R10: `sda_oe_o` changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Bus-mode select; the two-wire engine runs only while high |
| i2c_dis_i | input | 1 | Disable bit from the register file; forces the engine idle |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| reg_addr_o | output | AW | Register pointer, used as the read and write address |
| reg_wdata_o | output | 8 | Write data for the register file |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data at `reg_addr_o` (combinational) |

## Verification
Four properties are checked on every cycle:
- the quiet outputs while chip select is low or the disable bit is set;
- the pointer step that follows every write strobe;
- the rule that the data-line drive moves only while the synchronised clock is low.

Address matching and the rejection of reserved addresses can only be shown by the bench's scenarios, through the acknowledge bit. The same holds for read data order and burst increments, for the release after a NACK, and for the abandonment of a frame cut short by a repeated START.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_WR,
      ST_ACK,
      ST_TX,
      ST_RACK,
      ST_WAIT
   } slv_state_e;

endpackage

// File: rtl/i2c_regslave_sync.sv
module i2c_regslave_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2c_regslave_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d_i};
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/i2c_regslave_bus_evt.sv
module i2c_regslave_bus_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
   import i2c_regslave_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h1D,
   parameter int         SYNC_STAGES = 2,
   parameter int         AW          = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              i2c_dis_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [AW-1:0]     reg_addr_o,
   output logic [BYTE_W-1:0] reg_wdata_o,
   output logic              reg_we_o,
   input  logic [BYTE_W-1:0] reg_rdata_i
);

   localparam logic [2:0]    LAST_BIT = 3'(BYTE_W - 1);
   localparam logic [AW-1:0] PTR_ONE  = AW'(1);

   generate
      if (AW < 1 || AW > BYTE_W) begin : g_bad_aw
         $error("i2c_regslave: AW must lie between 1 and 8");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_regslave_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   ({scl_s, sda_s})
   );

   i2c_regslave_bus_evt evt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   slv_state_e        state, after_ack;
   logic              half;
   logic [2:0]        cnt;
   logic [6:0]        rx_sh;
   logic [6:0]        tx_sh;
   logic [AW-1:0]     ptr;
   logic              oe;
   logic              we_q;
   logic [BYTE_W-1:0] wdata;
   logic              active;
   logic [BYTE_W-1:0] rx_byte;

   assign active  = cs_i & ~i2c_dis_i;
   assign rx_byte = {rx_sh, sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         half      <= 1'b0;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         oe        <= 1'b0;
         we_q      <= 1'b0;
         wdata     <= '0;
      end else begin
         we_q <= 1'b0;
         if (we_q) ptr <= ptr + PTR_ONE;
         if (!active) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
            half  <= 1'b0;
            cnt   <= '0;
         end else if (start_det) begin
            state <= ST_DEV;
            oe    <= 1'b0;
            half  <= 1'b0;
            cnt   <= '0;
         end else if (stop_det) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
            half  <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_REG, ST_WR: begin
                  if (scl_rise) begin
                     rx_sh <= rx_byte[6:0];
                     cnt   <= cnt + 3'd1;
                     if (cnt == LAST_BIT) begin
                        half  <= 1'b0;
                        state <= ST_ACK;
                        if (state == ST_DEV) begin
                           if (rx_byte[7:1] == DEV_ADDR)
                              after_ack <= rx_byte[0] ? ST_TX : ST_REG;
                           else
                              state <= ST_WAIT;
                        end else if (state == ST_REG) begin
                           ptr       <= rx_byte[AW-1:0];
                           after_ack <= ST_WR;
                        end else begin
                           we_q      <= 1'b1;
                           wdata     <= rx_byte;
                           after_ack <= ST_WR;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (!half) begin
                        oe   <= 1'b1;
                        half <= 1'b1;
                     end else begin
                        half  <= 1'b0;
                        cnt   <= '0;
                        state <= after_ack;
                        if (after_ack == ST_TX) begin
                           tx_sh <= reg_rdata_i[6:0];
                           oe    <= ~reg_rdata_i[7];
                        end else begin
                           oe <= 1'b0;
                        end
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 3'd1;
                     if (cnt == LAST_BIT) begin
                        ptr   <= ptr + PTR_ONE;
                        state <= ST_RACK;
                        half  <= 1'b0;
                     end
                  end else if (scl_fall) begin
                     tx_sh <= {tx_sh[5:0], 1'b0};
                     oe    <= ~tx_sh[6];
                  end
               end
               ST_RACK: begin
                  if (!half) begin
                     if (scl_fall) begin
                        oe   <= 1'b0;
                        half <= 1'b1;
                     end
                  end else if (scl_rise) begin
                     if (sda_s) begin
                        state <= ST_WAIT;
                     end else begin
                        state     <= ST_ACK;
                        after_ack <= ST_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o    = oe;
   assign reg_addr_o  = ptr;
   assign reg_wdata_o = wdata;
   assign reg_we_o    = we_q;

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_i,
   input logic          i2c_dis_i,
   input logic          scl_s,
   input logic          sda_oe_o,
   input logic          reg_we_o,
   input logic [AW-1:0] reg_addr_o
);

   p_cs_low_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_i |=> (!sda_oe_o && !reg_we_o));

   p_disable_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      i2c_dis_i |=> (!sda_oe_o && !reg_we_o));

   p_ptr_step_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o |=> (reg_addr_o == AW'($past(reg_addr_o) + AW'(1))));

   p_drive_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe_o) && $past(cs_i) && !$past(i2c_dis_i)) |-> !$past(scl_s));

endmodule

bind i2c_regslave i2c_regslave_chk #(.AW(AW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_i       (cs_i),
   .i2c_dis_i  (i2c_dis_i),
   .scl_s      (scl_s),
   .sda_oe_o   (sda_oe_o),
   .reg_we_o   (reg_we_o),
   .reg_addr_o (reg_addr_o)
);

// File: tb/i2c_regslave_tb_top.sv
module i2c_regslave_tb_top;

   localparam int H = 16;

   logic       clk = 1'b0;
   logic       rst_n, cs, dis, scl_m, sda_m_low;
   logic       sda_oe, reg_we;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic [7:0] mem [256];
   wire        sda_bus = ~(sda_m_low | sda_oe);

   int n_chk = 0, n_fail = 0, r10_viol = 0;
   logic oe_seen = 1'b0, oe_prev = 1'b0, done = 1'b0;
   logic [15:0] exp_q [$];

   always #5 clk = ~clk;

   i2c_regslave dut_i (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .i2c_dis_i(dis),
      .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
      .reg_rdata_i(reg_rdata));

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
      end else if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
      end
   end
   assign reg_rdata = mem[reg_addr];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: register-file writes
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
         end else begin
            logic [15:0] item;
            item = exp_q.pop_front();
            check({reg_addr, reg_wdata} == item, "R5 write addr/data",
                  {reg_addr, reg_wdata}, item);
         end
      end
      if (sda_oe) oe_seen = 1'b1;
      if (sda_oe !== oe_prev && scl_m) r10_viol++;
      oe_prev = sda_oe;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m_low = 1'b0; wait_cyc(H);
      scl_m = 1'b1;     wait_cyc(H);
      sda_m_low = 1'b1; wait_cyc(H);
      scl_m = 1'b0;     wait_cyc(H);
   endtask

   task automatic bus_stop();
      sda_m_low = 1'b1; wait_cyc(H);
      scl_m = 1'b1;     wait_cyc(H);
      sda_m_low = 1'b0; wait_cyc(H);
   endtask

   task automatic send_bit(input logic b);
      wait_cyc(2);
      sda_m_low = ~b; wait_cyc(H);
      scl_m = 1'b1;   wait_cyc(H);
      scl_m = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      wait_cyc(2);
      sda_m_low = 1'b0; wait_cyc(H);
      scl_m = 1'b1;     wait_cyc(H/2);
      acked = ~sda_bus; wait_cyc(H/2);
      scl_m = 1'b0;
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] b);
      wait_cyc(2);
      sda_m_low = 1'b0;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         wait_cyc(H);
         scl_m = 1'b1; wait_cyc(H/2);
         b = {b[6:0], sda_bus};
         wait_cyc(H/2);
         scl_m = 1'b0;
      end
      wait_cyc(2);
      sda_m_low = give_ack; wait_cyc(H);
      scl_m = 1'b1;         wait_cyc(H);
      scl_m = 1'b0;
      wait_cyc(2);
      sda_m_low = 1'b0;
   endtask

   task automatic read_at_pointer(input logic [7:0] exp, input string req);
      logic a;
      logic [7:0] d;
      bus_start();
      write_byte(8'h3B, a);
      check(a, req, a, 1);
      read_byte(1'b0, d);
      check(d == exp, req, d, exp);
      bus_stop();
   endtask

   task automatic quiet_write_frame(input string req);
      logic a0, a1, a2;
      oe_seen = 1'b0;
      bus_start();
      write_byte(8'h3A, a0);
      write_byte(8'h30, a1);
      write_byte(8'h99, a2);
      bus_stop();
      check(!a0 && !a1 && !a2 && !oe_seen, req, {a0, a1, a2, oe_seen}, 0);
   endtask

   initial begin
      logic a;
      logic [7:0] d;
      logic [7:0] bad [4];
      bad[0] = 8'h00; bad[1] = 8'h3C; bad[2] = 8'hF0; bad[3] = 8'h08;
      rst_n = 1'b0; cs = 1'b1; dis = 1'b0; scl_m = 1'b1; sda_m_low = 1'b0;
      wait_cyc(5);
      check(!sda_oe && !reg_we, "reset outputs quiet", {sda_oe, reg_we}, 0);
      rst_n = 1'b1;
      wait_cyc(10);

      // R4/R5: write two registers from 0x10
      exp_q.push_back({8'h10, 8'h3C});
      exp_q.push_back({8'h11, 8'h81});
      bus_start();
      write_byte(8'h3A, a); check(a, "R1 own address ack", a, 1);
      write_byte(8'h10, a); check(a, "R4 register byte ack", a, 1);
      write_byte(8'h3C, a); check(a, "R5 data ack", a, 1);
      write_byte(8'h81, a); check(a, "R5 data ack", a, 1);
      bus_stop();

      // R6/R7/R8: burst read of three from 0x10
      bus_start();
      write_byte(8'h3A, a);
      write_byte(8'h10, a); check(a, "R4 pointer load ack", a, 1);
      bus_start();
      write_byte(8'h3B, a); check(a, "R6 read address ack", a, 1);
      read_byte(1'b1, d); check(d == 8'h3C, "R6 first byte MSB first", d, 8'h3C);
      read_byte(1'b1, d); check(d == 8'h81, "R7 second byte", d, 8'h81);
      read_byte(1'b0, d); check(d == 8'hB7, "R7 third byte", d, 8'hB7);
      oe_seen = 1'b0;
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      check(!oe_seen, "R8 released after NACK", oe_seen, 0);
      bus_stop();

      // R9: pointer survives stop, steps past NACKed byte
      read_at_pointer(8'hB6, "R9 pointer kept after stop");

      // R1: reserved and foreign addresses are not acknowledged
      foreach (bad[k]) begin
         logic a2;
         oe_seen = 1'b0;
         bus_start();
         write_byte(bad[k], a);
         write_byte(8'hAA, a2);
         bus_stop();
         check(!a && !a2 && !oe_seen, "R1 address rejected", {a, a2}, 0);
      end

      // R2: chip select low keeps engine idle, pointer untouched
      cs = 1'b0;
      quiet_write_frame("R2 cs low no ack");
      cs = 1'b1; wait_cyc(4);
      read_at_pointer(8'hB1, "R2 pointer unchanged");

      // R3: disable bit keeps engine idle
      dis = 1'b1;
      quiet_write_frame("R3 disabled no ack");
      dis = 1'b0; wait_cyc(4);
      read_at_pointer(8'hB0, "R3 pointer unchanged");

      // R9: START inside a data byte abandons it
      exp_q.push_back({8'h40, 8'h55});
      bus_start();
      write_byte(8'h3A, a);
      write_byte(8'h20, a);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      bus_start();
      write_byte(8'h3A, a); check(a, "R9 restart address ack", a, 1);
      write_byte(8'h40, a);
      write_byte(8'h55, a); check(a, "R9 new frame data ack", a, 1);
      bus_stop();
      wait_cyc(10);
      check(mem[8'h20] == 8'h85, "R9 partial byte not written", mem[8'h20], 8'h85);

      check(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
      check(r10_viol == 0, "R10 drive only with clock low", r10_viol, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule